// File: doc/BRIEF.md
# Condition Register Logical Unit

This block keeps a 32-bit condition register and carries out the small set of operations that work on it one bit or one nibble at a time. A bit operation reads two bits of the register, each picked by a 5-bit index, combines them with one of eight Boolean functions, and writes the result into a third indexed bit. A field move copies one 4-bit field, picked by a 3-bit index, into another field. Indices count from the most significant end, so index 0 is the top bit of the register and field 0 is its top nibble.

A decoder upstream presents one operation per cycle with a valid strobe. The result appears on the registered output one clock later. A parallel load port writes the whole register at once and wins over any operation presented in the same cycle. The full register value is always visible on the output.

Top module: `cr_logic_unit`

## Requirements
- R1: A synchronous active-high reset clears `cr_q` to 0 on the next rising edge.
- R2: Bit index i (0 to 31) refers to `cr_q[31-i]`, so index 0 is the most significant bit and index 31 the least significant.
- R3: With `op_sel` 0, 2 or 3 the target bit receives the AND, OR or XOR of source bits A and B.
- R4: With `op_sel` 1 or 4 the target bit receives the inverted AND or the inverted OR of source bits A and B.
- R5: With `op_sel` 5 the target bit receives the XNOR of source bits A and B.
- R6: With `op_sel` 6 the target bit receives A AND NOT B, and with `op_sel` 7 it receives A OR NOT B.
- R7: With `op_sel` 8 the 4-bit field at `src_fld` is copied into the field at `dst_fld`, where field n is `cr_q[31-4n:28-4n]`.
- R8: A bit operation (`op_sel` 0 to 7) changes at most the target bit; every other bit keeps its value.
- R9: A field move changes only the bits of field `dst_fld`.
- R10: Sources are read from the register value before the update, so a target that equals a source uses the old bit value; the result is visible after one clock edge.
- R11: Nothing changes when `op_valid` is low, or when `op_sel` is 9 to 15.
- R12: When `load_en` is high, `cr_q` takes `load_data` on the next edge, even if a valid operation is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code (0 to 8 used) |
| tgt_bit | input | 5 | Index of the bit that a bit operation writes |
| src_a_bit | input | 5 | Index of source bit A |
| src_b_bit | input | 5 | Index of source bit B |
| dst_fld | input | 3 | Field written by a field move |
| src_fld | input | 3 | Field read by a field move |
| load_en | input | 1 | Parallel load enable |
| load_data | input | 32 | Parallel load value |
| cr_q | output | 32 | Registered condition register |

## Verification
Each of the eight bit functions is tried against all four combinations of source values, over a background that has both ones and zeros next to the target. This separates each function from its neighbours and shows whether any bit other than the target is disturbed. Indices at both ends of the register show whether the MSB-first numbering is mirrored. Field moves in both directions, and a target that is also a source, show whether pre-update values are used. Strobes that are held low, unused opcodes and loads that coincide with an operation show whether the register is held or which write wins.

// File: rtl/crlu_pkg.sv
package crlu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND   = 4'd0,
    OP_NAND  = 4'd1,
    OP_OR    = 4'd2,
    OP_XOR   = 4'd3,
    OP_NOR   = 4'd4,
    OP_EQV   = 4'd5,
    OP_ANDC  = 4'd6,
    OP_ORC   = 4'd7,
    OP_FMOVE = 4'd8
  } cr_op_e;

  function automatic logic op_is_bitwise(logic [OP_W-1:0] op);
    return op <= OP_ORC;
  endfunction

  function automatic logic op_is_fmove(logic [OP_W-1:0] op);
    return op == OP_FMOVE;
  endfunction

endpackage

// File: rtl/crlu_bit_pick.sv
module crlu_bit_pick #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);

  logic [W-1:0] rev;

  // Mirror the vector so that index 0 lands on the most significant bit.
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev[g] = vec[W-1-g];
  end

  assign bit_o = rev[idx];

endmodule

// File: rtl/crlu_logic_op.sv
module crlu_logic_op
  import crlu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            a,
  input  logic            b,
  output logic            res
);

  always_comb begin
    case (cr_op_e'(op))
      OP_AND:  res = a & b;
      OP_NAND: res = ~(a & b);
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOR:  res = ~(a | b);
      OP_EQV:  res = ~(a ^ b);
      OP_ANDC: res = a & ~b;
      OP_ORC:  res = a | ~b;
      default: res = 1'b0;
    endcase
  end

endmodule

// File: rtl/crlu_field_move.sv
module crlu_field_move #(
  parameter int W      = 32,
  parameter int FLD_W  = 4,
  parameter int NFLD   = W / FLD_W,
  parameter int FIDX_W = $clog2(NFLD)
) (
  input  logic [W-1:0]      vec,
  input  logic [FIDX_W-1:0] src_fld,
  input  logic [FIDX_W-1:0] dst_fld,
  output logic [W-1:0]      moved
);

  logic [NFLD-1:0][FLD_W-1:0] fields;
  logic [FLD_W-1:0]           src_val;

  // fields[n] holds field n in MSB-first numbering.
  for (genvar g = 0; g < NFLD; g++) begin : g_split
    assign fields[g] = vec[W-1-FLD_W*g -: FLD_W];
  end

  assign src_val = fields[src_fld];

  for (genvar g = 0; g < NFLD; g++) begin : g_merge
    assign moved[W-1-FLD_W*g -: FLD_W] =
      (dst_fld == FIDX_W'(g)) ? src_val : fields[g];
  end

endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit
  import crlu_pkg::*;
#(
  parameter int CR_W   = 32,
  parameter int FLD_W  = 4,
  parameter int IDX_W  = $clog2(CR_W),
  parameter int FIDX_W = $clog2(CR_W / FLD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [IDX_W-1:0]  tgt_bit,
  input  logic [IDX_W-1:0]  src_a_bit,
  input  logic [IDX_W-1:0]  src_b_bit,
  input  logic [FIDX_W-1:0] dst_fld,
  input  logic [FIDX_W-1:0] src_fld,
  input  logic              load_en,
  input  logic [CR_W-1:0]   load_data,
  output logic [CR_W-1:0]   cr_q
);

  localparam int NFLD = CR_W / FLD_W;

  logic            bit_a, bit_b, bit_res;
  logic [CR_W-1:0] bit_next, fld_next, cr_d;
  logic [CR_W-1:0] tgt_hit;

  crlu_bit_pick #(.W(CR_W), .IDX_W(IDX_W)) u_pick_a (
    .vec(cr_q), .idx(src_a_bit), .bit_o(bit_a)
  );

  crlu_bit_pick #(.W(CR_W), .IDX_W(IDX_W)) u_pick_b (
    .vec(cr_q), .idx(src_b_bit), .bit_o(bit_b)
  );

  crlu_logic_op u_op (
    .op(op_sel), .a(bit_a), .b(bit_b), .res(bit_res)
  );

  crlu_field_move #(.W(CR_W), .FLD_W(FLD_W), .NFLD(NFLD), .FIDX_W(FIDX_W)) u_fmove (
    .vec(cr_q), .src_fld(src_fld), .dst_fld(dst_fld), .moved(fld_next)
  );

  // One-hot target decode, MSB-first.
  for (genvar g = 0; g < CR_W; g++) begin : g_tgt
    assign tgt_hit[g]  = (tgt_bit == IDX_W'(CR_W-1-g));
    assign bit_next[g] = tgt_hit[g] ? bit_res : cr_q[g];
  end

  always_comb begin
    cr_d = cr_q;
    if (load_en)                              cr_d = load_data;
    else if (op_valid && op_is_bitwise(op_sel)) cr_d = bit_next;
    else if (op_valid && op_is_fmove(op_sel))   cr_d = fld_next;
  end

  always_ff @(posedge clk) begin
    if (rst) cr_q <= '0;
    else     cr_q <= cr_d;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> cr_q == '0); // R1

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_en |=> cr_q == $past(load_data)); // R12

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_en && (!op_valid || op_sel > 4'd8)) |=> $stable(cr_q)); // R11

  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (!load_en && op_valid && op_sel <= 4'd7)
      |=> $countones(cr_q ^ $past(cr_q)) <= 1); // R8

  AST_FIELD_CONFINED: assert property (@(posedge clk) disable iff (rst)
    (!load_en && op_valid && op_sel == 4'd8)
      |=> ((cr_q ^ $past(cr_q)) &
           ~($past({{(CR_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << (CR_W-FLD_W-FLD_W*dst_fld)))) == '0); // R9

endmodule

// File: tb/tb_cr_logic_unit.sv
module tb_cr_logic_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic [4:0]  tgt_bit, src_a_bit, src_b_bit;
  logic [2:0]  dst_fld, src_fld;
  logic        load_en;
  logic [31:0] load_data;
  logic [31:0] cr_q;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model;

  always #2 clk = ~clk; // 250 MHz

  cr_logic_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .tgt_bit(tgt_bit), .src_a_bit(src_a_bit), .src_b_bit(src_b_bit),
    .dst_fld(dst_fld), .src_fld(src_fld), .load_en(load_en),
    .load_data(load_data), .cr_q(cr_q)
  );

  function automatic logic getb(logic [31:0] v, int i);
    return v[31-i];
  endfunction

  function automatic logic fn(int op, logic a, logic b);
    case (op)
      0: return a & b;
      1: return !(a && b);
      2: return a | b;
      3: return a ^ b;
      4: return !(a || b);
      5: return a == b;
      6: return a & !b;
      7: return a | !b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 2, 3: return "R3";
      1, 4:    return "R4";
      5:       return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [31:0] apply(logic [31:0] v, int op, int t, int a, int b,
                                        int df, int sf);
    logic [31:0] r = v;
    if (op <= 7) r[31-t] = fn(op, getb(v, a), getb(v, b));
    else if (op == 8) for (int k = 0; k < 4; k++) r[31-4*df-k] = v[31-4*sf-k];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 0; load_en = 0; op_sel = 0;
  endtask

  task automatic do_load(logic [31:0] v);
    @(negedge clk);
    load_en = 1; load_data = v;
    @(negedge clk);
    idle();
    model = v;
  endtask

  task automatic do_op(int op, int t, int a, int b, int df, int sf);
    @(negedge clk);
    op_valid = 1; op_sel = 4'(op);
    tgt_bit = 5'(t); src_a_bit = 5'(a); src_b_bit = 5'(b);
    dst_fld = 3'(df); src_fld = 3'(sf);
    @(negedge clk);
    idle();
    model = apply(model, op, t, a, b, df, sf);
  endtask

  task automatic test_reset();
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    check("R1 reset clear", cr_q, 32'h0);
    do_load(32'hFFFF_FFFF);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    check("R1 reset after load", cr_q, 32'h0);
    model = 0;
  endtask

  task automatic test_bitops();
    // sources at index 2 and 9, target 20; neighbours 19 and 21 set
    for (int op = 0; op < 8; op++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] bg = 32'h0000_1C00 ^ 32'h0000_0800; // bits 12,10 set: index 19,21
        bg[31-2] = p[1];
        bg[31-9] = p[0];
        do_load(bg);
        do_op(op, 20, 2, 9, 0, 0);
        check({tag_of(op), " R8 bit op"}, cr_q, model);
      end
    end
  endtask

  task automatic test_mapping();
    do_load(32'h8000_0001);
    do_op(0, 5, 0, 31, 0, 0);
    check("R2 MSB-first index", cr_q, 32'h8400_0001);
    do_load(32'h8000_0000);
    do_op(2, 31, 0, 30, 0, 0);
    check("R2 index 31 is LSB", cr_q, 32'h8000_0001);
  endtask

  task automatic test_selfref();
    do_load(32'h0);
    do_op(1, 3, 3, 3, 0, 0);
    check("R10 target equals source", cr_q, 32'h1000_0000);
    do_op(1, 3, 3, 3, 0, 0);
    check("R10 uses old value", cr_q, 32'h0);
  endtask

  task automatic test_fmove();
    do_load(32'h1234_5678);
    do_op(8, 0, 0, 0, 6, 1);
    check("R7 R9 move 1 to 6", cr_q, 32'h1234_5628);
    do_op(8, 0, 0, 0, 0, 7);
    check("R7 R9 move 7 to 0", cr_q, 32'h8234_5628);
    do_op(8, 0, 0, 0, 3, 3);
    check("R9 move onto itself", cr_q, 32'h8234_5628);
  endtask

  task automatic test_ignore();
    do_load(32'hA5A5_0F0F);
    @(negedge clk);
    op_valid = 0; op_sel = 4'd2; tgt_bit = 0; src_a_bit = 7; src_b_bit = 7;
    @(negedge clk);
    check("R11 valid low", cr_q, 32'hA5A5_0F0F);
    for (int op = 9; op < 16; op++) begin
      @(negedge clk);
      op_valid = 1; op_sel = 4'(op); tgt_bit = 1; dst_fld = 0; src_fld = 7;
      @(negedge clk);
      idle();
      check("R11 unused opcode", cr_q, 32'hA5A5_0F0F);
    end
  endtask

  task automatic test_priority();
    do_load(32'h0);
    @(negedge clk);
    load_en = 1; load_data = 32'h0000_FFFF;
    op_valid = 1; op_sel = 4'd1; tgt_bit = 0; src_a_bit = 1; src_b_bit = 1;
    @(negedge clk);
    idle();
    check("R12 load beats op", cr_q, 32'h0000_FFFF);
  endtask

  initial begin
    rst = 1; idle();
    tgt_bit = 0; src_a_bit = 0; src_b_bit = 0; dst_fld = 0; src_fld = 0;
    load_data = 0; model = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    test_reset();
    test_bitops();
    test_mapping();
    test_selfref();
    test_fmove();
    test_ignore();
    test_priority();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule